// File: doc/BRIEF.md
# Cache-Line Access Splitter

The splitter accepts one memory access at a time, described by a byte address, a byte count and an optional per-byte enable mask. It breaks the access into fragments so that each fragment lies wholly inside one aligned cache line. The first fragment runs from the start address up to the next line boundary. Any full lines follow. A final piece carries whatever bytes remain. An access that stays inside one line leaves as a single fragment. Every fragment carries its own address, its byte count, the matching slice of the enable mask and the sequence number of the instruction that issued the access.

Fragments go out in address order on a valid/ready port that stands for the cache port. A fragment the port refuses is held unchanged and offered again. A tracker counts fragments in flight and responses already returned. A fragment is offered only while the sum of those two counts is below the fragment total. When every response has come back, a one-cycle done pulse closes the access. An atomic read-modify-write access that would need more than one fragment is refused: it is taken off the input, no fragment is sent, and a one-cycle fault pulse is raised.

The control is a five-state machine. IDLE accepts an access and moves to SEND, or to FAULT for an atomic access that crosses a line. SEND moves to DRAIN when the last fragment is accepted. DRAIN moves to DONE once all responses are counted. DONE and FAULT each last one cycle and then return to IDLE.

Top module: `line_splitter`

## Requirements
- R1: `acc_ready` is high only in IDLE. An access is taken on a cycle where `acc_valid` and `acc_ready` are both high, and `acc_ready` stays low until that access ends.
- R2: An access that does not cross a line boundary produces exactly one fragment. That fragment has the access address and size, and `frag_last` is 1.
- R3: The first fragment of a crossing access starts at the access address. Its size is the next line-aligned address minus the start address, so every fragment satisfies (address mod LINE_BYTES) + size <= LINE_BYTES.
- R4: Each fragment between the first and the last is LINE_BYTES long and starts at the line-aligned address that follows the previous fragment.
- R5: The final fragment covers the remaining bytes and is never empty. `frag_last` is 1 on that fragment only, and the fragment sizes add up to the access size.
- R6: Bit i of `frag_be` equals bit (k + i) of `acc_be`, where k is the number of bytes in the earlier fragments, for i below the fragment size. Bits at or above the size are 0. When `acc_be_en` is 0, the low `frag_size` bits are 1.
- R7: Every fragment carries the `acc_seq` value of its access on `frag_seq`.
- R8: An atomic access (`acc_atomic`=1) that crosses a line raises `acc_fault` for exactly one cycle, in the cycle after acceptance. It emits no fragment, and the splitter then returns to IDLE. An atomic access inside one line is split normally.
- R9: A fragment offered with `frag_ready` low stays offered, with address, size, mask and tag unchanged, until it is accepted. Fragments are never reordered.
- R10: A fragment is offered only while received plus outstanding responses are fewer than the fragment total. No access emits more fragments than the lines it touches.
- R11: `acc_done` pulses for one cycle only after the number of `rsp_valid` pulses equals the fragment count. `acc_ready` is high in the following cycle.
- R12: After reset `acc_ready` is 1 and `frag_valid`, `acc_done` and `acc_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Splitter idle and able to take an access |
| acc_addr | input | ADDR_W | Start byte address |
| acc_size | input | $clog2(MAX_SIZE+1) | Byte count, 1 to MAX_SIZE |
| acc_be | input | MAX_SIZE | Per-byte enable, bit 0 = first byte |
| acc_be_en | input | 1 | 1 when acc_be is meaningful |
| acc_atomic | input | 1 | Access is an atomic read-modify-write |
| acc_seq | input | SEQ_W | Instruction sequence number |
| frag_valid | output | 1 | Fragment offered to the cache port |
| frag_ready | input | 1 | Cache port takes the fragment |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_size | output | $clog2(LINE_BYTES+1) | Fragment byte count |
| frag_be | output | LINE_BYTES | Fragment byte enables |
| frag_seq | output | SEQ_W | Sequence tag |
| frag_last | output | 1 | Final fragment of the access |
| rsp_valid | input | 1 | One response returned |
| acc_done | output | 1 | All responses back |
| acc_fault | output | 1 | Atomic access refused for crossing a line |

## Verification
The bench builds the splitter with LINE_BYTES = 16, MAX_SIZE = 64, ADDR_W = 16 and SEQ_W = 8. With a line this short, a 64-byte access starting mid-line yields a head, three full middle lines and a tail, so every fragment kind and a five-fragment response count are exercised. With MAX_SIZE at four lines, the byte-enable offset reaches the top of the mask, so slicing at the far end of the vector is exercised. The cache port refuses fragments at random in some passes, and responses come back at random delays, some of them while later fragments are still going out.

// File: rtl/line_split_pkg.sv
package line_split_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DRAIN,
        ST_DONE,
        ST_FAULT
    } split_state_e;

endpackage

// File: rtl/line_split_calc.sv
module line_split_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_SIZE   = 64,
    localparam int LOG_LINE  = $clog2(LINE_BYTES),
    localparam int SIZE_W    = $clog2(MAX_SIZE + 1),
    localparam int LSIZE_W   = $clog2(LINE_BYTES + 1)
) (
    input  logic [ADDR_W-1:0]     cur_addr,
    input  logic [SIZE_W-1:0]     remain,
    input  logic [MAX_SIZE-1:0]   be_vec,
    input  logic [SIZE_W-1:0]     be_off,
    output logic [LSIZE_W-1:0]    piece_size,
    output logic [LINE_BYTES-1:0] piece_be,
    output logic                  piece_last
);

    localparam int CW = ((SIZE_W > LSIZE_W) ? SIZE_W : LSIZE_W) + 1;
    localparam int EW = MAX_SIZE + LINE_BYTES;

    logic [LOG_LINE-1:0]   line_off;
    logic [CW-1:0]         room;
    logic [CW-1:0]         rem_w;
    logic [CW-1:0]         take;
    logic [EW-1:0]         be_ext;
    logic [LINE_BYTES-1:0] window;

    always_comb begin
        line_off   = cur_addr[LOG_LINE-1:0];
        room       = CW'(LINE_BYTES) - CW'(line_off);
        rem_w      = CW'(remain);
        take       = (rem_w < room) ? rem_w : room;
        piece_last = (rem_w <= room);
        piece_size = LSIZE_W'(take);
        be_ext     = {{LINE_BYTES{1'b0}}, be_vec} >> be_off;
        window     = be_ext[LINE_BYTES-1:0];
    end

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_be
        assign piece_be[i] = window[i] && (CW'(i) < take);
    end

endmodule

// File: rtl/line_split_track.sv
module line_split_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] total_in,
    input  logic             issue,
    input  logic             resp,
    output logic             can_issue,
    output logic             all_back
);

    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] out_q;
    logic [CNT_W-1:0] rcv_q;
    logic             resp_ok;

    assign resp_ok = resp && (out_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            out_q   <= '0;
            rcv_q   <= '0;
        end else if (start) begin
            total_q <= total_in;
            out_q   <= '0;
            rcv_q   <= '0;
        end else begin
            if (issue && !resp_ok) begin
                out_q <= out_q + 1'b1;
            end else if (!issue && resp_ok) begin
                out_q <= out_q - 1'b1;
            end
            if (resp_ok) begin
                rcv_q <= rcv_q + 1'b1;
            end
        end
    end

    always_comb begin
        can_issue = ({1'b0, rcv_q} + {1'b0, out_q}) < {1'b0, total_q};
        all_back  = (rcv_q == total_q) && (total_q != '0);
    end

    AST_NO_OVERISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rcv_q} + {1'b0, out_q}) <= {1'b0, total_q}) else $error("over-issue"); // R10

    AST_RCV_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && resp && out_q == '0) |=> $stable(rcv_q)) else $error("stray response counted"); // R11

endmodule

// File: rtl/line_splitter.sv
module line_splitter
    import line_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_SIZE   = 64,
    parameter int SEQ_W      = 16,
    localparam int LOG_LINE  = $clog2(LINE_BYTES),
    localparam int SIZE_W    = $clog2(MAX_SIZE + 1),
    localparam int LSIZE_W   = $clog2(LINE_BYTES + 1),
    localparam int MAX_FRAGS = (MAX_SIZE + 2 * LINE_BYTES - 2) / LINE_BYTES,
    localparam int CNT_W     = $clog2(MAX_FRAGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    output logic                  acc_ready,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [SIZE_W-1:0]     acc_size,
    input  logic [MAX_SIZE-1:0]   acc_be,
    input  logic                  acc_be_en,
    input  logic                  acc_atomic,
    input  logic [SEQ_W-1:0]      acc_seq,
    output logic                  frag_valid,
    input  logic                  frag_ready,
    output logic [ADDR_W-1:0]     frag_addr,
    output logic [LSIZE_W-1:0]    frag_size,
    output logic [LINE_BYTES-1:0] frag_be,
    output logic [SEQ_W-1:0]      frag_seq,
    output logic                  frag_last,
    input  logic                  rsp_valid,
    output logic                  acc_done,
    output logic                  acc_fault
);

    split_state_e state_q, state_d;

    logic [ADDR_W-1:0]   cur_addr_q;
    logic [SIZE_W-1:0]   remain_q;
    logic [SIZE_W-1:0]   be_off_q;
    logic [MAX_SIZE-1:0] be_q;
    logic [SEQ_W-1:0]    seq_q;

    logic [ADDR_W-1:0]          end_addr;
    logic [ADDR_W-LOG_LINE-1:0] line_span;
    logic [CNT_W-1:0]           line_count;
    logic                       crosses;
    logic                       take_acc;
    logic                       frag_fire;
    logic [LSIZE_W-1:0]         piece_size;
    logic [LINE_BYTES-1:0]      piece_be;
    logic                       piece_last;
    logic                       can_issue;
    logic                       all_back;

    // number of lines the incoming access touches
    always_comb begin
        end_addr   = acc_addr + ADDR_W'(acc_size) - 1'b1;
        line_span  = end_addr[ADDR_W-1:LOG_LINE] - acc_addr[ADDR_W-1:LOG_LINE];
        line_count = CNT_W'(line_span) + 1'b1;
        crosses    = (line_span != '0);
        take_acc   = acc_valid && (state_q == ST_IDLE);
        frag_fire  = frag_valid && frag_ready;
    end

    line_split_calc #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .MAX_SIZE   (MAX_SIZE)
    ) u_calc (
        .cur_addr   (cur_addr_q),
        .remain     (remain_q),
        .be_vec     (be_q),
        .be_off     (be_off_q),
        .piece_size (piece_size),
        .piece_be   (piece_be),
        .piece_last (piece_last)
    );

    line_split_track #(
        .CNT_W (CNT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take_acc),
        .total_in  (line_count),
        .issue     (frag_fire),
        .resp      (rsp_valid),
        .can_issue (can_issue),
        .all_back  (all_back)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_valid) begin
                    state_d = (acc_atomic && crosses) ? ST_FAULT : ST_SEND;
                end
            end
            ST_SEND: begin
                if (frag_fire && piece_last) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (all_back) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // fragment cursor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            remain_q   <= '0;
            be_off_q   <= '0;
            be_q       <= '0;
            seq_q      <= '0;
        end else if (take_acc) begin
            cur_addr_q <= acc_addr;
            remain_q   <= acc_size;
            be_off_q   <= '0;
            be_q       <= acc_be_en ? acc_be : {MAX_SIZE{1'b1}};
            seq_q      <= acc_seq;
        end else if (frag_fire) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(piece_size);
            remain_q   <= remain_q - SIZE_W'(piece_size);
            be_off_q   <= be_off_q + SIZE_W'(piece_size);
        end
    end

    // outputs
    always_comb begin
        acc_ready  = (state_q == ST_IDLE);
        frag_valid = (state_q == ST_SEND) && can_issue;
        acc_done   = (state_q == ST_DONE);
        acc_fault  = (state_q == ST_FAULT);
        frag_addr  = cur_addr_q;
        frag_size  = piece_size;
        frag_be    = piece_be;
        frag_seq   = seq_q;
        frag_last  = piece_last;
    end

    AST_HOLD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr)
            && $stable(frag_size) && $stable(frag_be) && $stable(frag_seq))) else $error("refused fragment changed"); // R9

    AST_FRAG_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> ((LSIZE_W+1)'(frag_addr[LOG_LINE-1:0]) + (LSIZE_W+1)'(frag_size)
            <= (LSIZE_W+1)'(LINE_BYTES))) else $error("fragment leaves its line"); // R3

    AST_FRAG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (frag_size != '0)) else $error("empty fragment"); // R5

    AST_FAULT_NO_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |=> (!frag_valid && acc_ready && !acc_fault)) else $error("fault not clean"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> (!acc_done && acc_ready)) else $error("done not a pulse"); // R11

    AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(all_back)) else $error("done before responses"); // R11

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid || acc_done) |-> !acc_ready) else $error("ready while busy"); // R1

endmodule

// File: tb/line_splitter_tb.sv
module line_splitter_tb;

    localparam int ADDR_W  = 16;
    localparam int LINE    = 16;
    localparam int MAXS    = 64;
    localparam int SEQ_W   = 8;
    localparam int SIZE_W  = $clog2(MAXS + 1);
    localparam int LSIZE_W = $clog2(LINE + 1);

    typedef struct {
        logic [ADDR_W-1:0] a;
        int                s;
        logic [LINE-1:0]   be;
        logic [SEQ_W-1:0]  seq;
        bit                last;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic acc_ready;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [SIZE_W-1:0] acc_size = '0;
    logic [MAXS-1:0] acc_be = '0;
    logic acc_be_en = 1'b0;
    logic acc_atomic = 1'b0;
    logic [SEQ_W-1:0] acc_seq = '0;
    logic frag_valid;
    logic frag_ready = 1'b0;
    logic [ADDR_W-1:0] frag_addr;
    logic [LSIZE_W-1:0] frag_size;
    logic [LINE-1:0] frag_be;
    logic [SEQ_W-1:0] frag_seq;
    logic frag_last;
    logic rsp_valid = 1'b0;
    logic acc_done;
    logic acc_fault;

    int n_checks = 0;
    int n_fail = 0;
    exp_t q[$];
    int pending = 0;
    int rsp_sent = 0;
    int exp_total = 0;
    bit ready_random = 1'b0;
    bit prev_refused = 1'b0;
    logic [ADDR_W-1:0] prev_addr;
    logic [LSIZE_W-1:0] prev_size;
    logic [LINE-1:0] prev_be;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    line_splitter #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE),
        .MAX_SIZE   (MAXS),
        .SEQ_W      (SEQ_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_ready  (acc_ready),
        .acc_addr   (acc_addr),
        .acc_size   (acc_size),
        .acc_be     (acc_be),
        .acc_be_en  (acc_be_en),
        .acc_atomic (acc_atomic),
        .acc_seq    (acc_seq),
        .frag_valid (frag_valid),
        .frag_ready (frag_ready),
        .frag_addr  (frag_addr),
        .frag_size  (frag_size),
        .frag_be    (frag_be),
        .frag_seq   (frag_seq),
        .frag_last  (frag_last),
        .rsp_valid  (rsp_valid),
        .acc_done   (acc_done),
        .acc_fault  (acc_fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // port-side stimulus: ready and responses, changed just after the edge
    always @(posedge clk) begin
        #2;
        frag_ready <= ready_random ? (($urandom % 3) != 0) : 1'b1;
        rsp_valid  <= (pending > 0) && (($urandom % 3) != 0);
    end

    // monitor and scoreboard, sampling mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_refused) begin
                chk(frag_valid && frag_addr == prev_addr && frag_size == prev_size
                    && frag_be == prev_be, "R9", "held fragment", frag_addr, prev_addr);
            end
            prev_refused = frag_valid && !frag_ready;
            prev_addr = frag_addr;
            prev_size = frag_size;
            prev_be   = frag_be;
            if (frag_valid && frag_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10", "fragment beyond total", frag_addr, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(frag_addr == e.a, "R3 R4", "addr", frag_addr, e.a);
                    chk(int'(frag_size) == e.s, "R2 R5", "size", frag_size, e.s);
                    chk(frag_be == e.be, "R6", "byte enable", frag_be, e.be);
                    chk(frag_seq == e.seq, "R7", "seq tag", frag_seq, e.seq);
                    chk(frag_last == e.last, "R5", "last flag", frag_last, e.last);
                end
                pending++;
            end
            if (rsp_valid) begin
                pending--;
                rsp_sent++;
            end
        end
    end

    task automatic run_access(input logic [ADDR_W-1:0] a, input int sz,
                              input logic [MAXS-1:0] be, input bit be_en,
                              input bit atomic, input logic [SEQ_W-1:0] seq);
        int rem;
        int off;
        int lines;
        logic [ADDR_W-1:0] ca;
        bit fault_exp;
        int guard;
        // expected fragments built from the line rules
        lines = ((int'(a) + sz - 1) / LINE) - (int'(a) / LINE) + 1;
        fault_exp = atomic && (lines > 1);
        exp_total = fault_exp ? 0 : lines;
        rsp_sent = 0;
        if (!fault_exp) begin
            rem = sz;
            off = 0;
            ca = a;
            while (rem > 0) begin
                exp_t e;
                int room;
                room = LINE - (int'(ca) % LINE);
                e.a = ca;
                e.s = (rem < room) ? rem : room;
                for (int i = 0; i < LINE; i++) begin
                    e.be[i] = (i < e.s) ? (be_en ? be[off + i] : 1'b1) : 1'b0;
                end
                e.seq = seq;
                rem -= e.s;
                e.last = (rem == 0);
                off += e.s;
                ca += ADDR_W'(e.s);
                q.push_back(e);
            end
        end
        @(posedge clk);
        #2;
        acc_valid  = 1'b1;
        acc_addr   = a;
        acc_size   = SIZE_W'(sz);
        acc_be     = be;
        acc_be_en  = be_en;
        acc_atomic = atomic;
        acc_seq    = seq;
        guard = 0;
        forever begin
            @(negedge clk);
            if (acc_ready || guard > 100) break;
            guard++;
        end
        @(posedge clk);
        #2;
        acc_valid = 1'b0;
        @(negedge clk);
        if (fault_exp) begin
            chk(acc_fault == 1'b1, "R8", "fault pulse", acc_fault, 1);
            chk(frag_valid == 1'b0, "R8", "no fragment on fault", frag_valid, 0);
            @(negedge clk);
            chk(acc_fault == 1'b0 && acc_ready == 1'b1, "R8", "fault ends, idle",
                {acc_fault, acc_ready}, 2'b01);
            chk(q.size() == 0 && pending == 0, "R8", "nothing emitted", pending, 0);
        end else begin
            chk(acc_ready == 1'b0, "R1", "busy after accept", acc_ready, 0);
            guard = 0;
            while (!acc_done && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
            chk(acc_done == 1'b1, "R11", "done seen", acc_done, 1);
            chk(rsp_sent == exp_total, "R11", "responses before done", rsp_sent, exp_total);
            chk(q.size() == 0, "R10", "all fragments emitted", q.size(), 0);
            @(negedge clk);
            chk(acc_done == 1'b0 && acc_ready == 1'b1, "R11", "pulse then idle",
                {acc_done, acc_ready}, 2'b01);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [MAXS-1:0] pat;
        pat = 64'hF0E1_D2C3_B4A5_9687;
        #45;
        chk(acc_ready == 1'b1 && frag_valid == 1'b0 && acc_done == 1'b0 && acc_fault == 1'b0,
            "R12", "reset state", {acc_ready, frag_valid, acc_done, acc_fault}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_access(16'h0100, 8, '0, 1'b0, 1'b0, 8'h11);   // R2 inside one line
        run_access(16'h010C, 8, pat, 1'b1, 1'b0, 8'h22);  // R3 R5 head plus tail
        run_access(16'h0103, 64, pat, 1'b1, 1'b0, 8'h33); // R4 R6 head, middles, tail
        run_access(16'h0120, 48, pat, 1'b1, 1'b0, 8'h44); // R4 aligned full lines
        run_access(16'h00FA, 20, '0, 1'b0, 1'b0, 8'h55);  // R6 no mask given
        run_access(16'h010F, 1, pat, 1'b1, 1'b0, 8'h66);  // R2 last byte of line
        run_access(16'h020C, 8, pat, 1'b1, 1'b1, 8'h77);  // R8 atomic crossing
        run_access(16'h0204, 8, pat, 1'b1, 1'b1, 8'h88);  // R8 atomic inside line
        ready_random = 1'b1;                              // R9 refusals
        run_access(16'h0305, 64, ~pat, 1'b1, 1'b0, 8'h99);
        run_access(16'h0410, 40, pat, 1'b1, 1'b0, 8'hAA);
        run_access(16'h04F8, 33, '0, 1'b0, 1'b0, 8'hBB);
        run_access(16'hFFF8, 16, pat, 1'b1, 1'b0, 8'hCC); // address wrap
        ready_random = 1'b0;
        run_access(16'h0500, 16, pat, 1'b1, 1'b0, 8'hDD); // R2 exactly one line

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule